// File: doc/BRIEF.md
# PCI Bus Master Write Engine

This block is the initiator side of a PCI memory-write path. The local side hands it a starting byte address, a number of DWords and a burst-enable bit. The engine then requests the bus and moves the DWords into system memory. It reads each DWord and its active-low byte enables from a local store that is indexed by the engine's own word counter. It drives REQ#, FRAME#, IRDY#, C/BE#, AD and PAR, and it samples GNT#, DEVSEL#, TRDY# and STOP#.

The engine has two write policies. With the burst bit clear, each DWord travels in its own single-data-phase transaction. FRAME# is released between these transactions, and REQ# is held until the final address phase. With the burst bit set, the whole request goes out as one linear burst under one grant. A target that never claims the cycle causes a master abort. A target that signals STOP# ends the transfer early. In both cases the error flag is raised to the local side.

Top module: `mw_pci_write_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, req_n, frame_n and irdy_n are high, and busy, done and err are low.
- R2: In every address phase (frame_n low, irdy_n high) C/BE# carries 4'b0111 (memory write) and AD carries the transaction's DWord address with AD[1:0] = 2'b00, even when start_addr[1:0] is not zero.
- R3: IRDY# goes low in the clock that follows every address phase.
- R4: In each data phase AD carries DWord i of the local store and C/BE# carries that word's q_be_n. Both stay unchanged in every cycle in which TRDY# or DEVSEL# is high, until the phase completes.
- R5: With burst_en = 1 the whole request is one transaction: one address phase at start_addr with bits [1:0] cleared, followed by data phases for words 0..N-1 at incrementing addresses.
- R6: In a burst, FRAME# is low in every data phase except the last one, and high during the final data phase.
- R7: With burst_en = 0, each DWord i gets its own transaction at address base + 4*i. FRAME# is high during every data phase, and FRAME# never goes low in the clock right after a final data phase.
- R8: REQ# stays low from the request until the address phase of the final transaction. It is high in that address phase and in every cycle after it.
- R9: In the clock after any cycle with FRAME# or IRDY# low, PAR equals the XOR of AD[31:0] and C/BE#[3:0] of that cycle.
- R10: If DEVSEL# is not low in any of the four clocks after an address phase, the sequence ends with err = 1. No data phase completes and no further address phase is issued.
- R11: If STOP# is low in a data phase, the sequence ends after that phase. A DWord with TRDY# low in that phase counts as transferred. err is set unless that word was the last one.
- R12: A start with dword_cnt = 0 is ignored. REQ# stays high and busy stays low.
- R13: done pulses high for exactly one cycle when a sequence ends, with busy low in that cycle. err is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a write sequence |
| start_addr | input | 32 | Byte address of the first DWord |
| dword_cnt | input | CNT_W | Number of DWords to write |
| burst_en | input | 1 | 1 = one linear burst, 0 = single-phase transactions |
| q_idx | output | CNT_W | Index of the DWord currently presented on AD |
| q_data | input | 32 | Local store word at q_idx |
| q_be_n | input | 4 | Active-low byte enables of the word at q_idx |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err | output | 1 | Last sequence ended by master abort or target stop |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | FRAME#, active low |
| irdy_n | output | 1 | IRDY#, active low |
| devsel_n | input | 1 | DEVSEL#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| stop_n | input | 1 | STOP#, active low |
| ad | output | 32 | Multiplexed address/data |
| cbe_n | output | 4 | Command / byte enables, active low |
| par | output | 1 | Even parity over the previous cycle's AD and C/BE# |

## Verification
The bench aims at the last-phase FRAME# release in bursts. A design that drops FRAME# one phase early or late shows the wrong FRAME# level in the logged data phases. It checks REQ# at every address phase of a single-phase sequence. An engine that releases the request too soon would have REQ# high at an early address phase, and one that releases it too late would have REQ# still low at the final one. DEVSEL# is delayed to the fourth clock, where the claim must still be accepted. It is also never given, where an engine with an off-by-one timer either aborts a valid cycle or keeps waiting. Target waits and a mid-burst STOP# show whether data is held through stalls and whether the disconnected word is counted exactly once.

// File: rtl/mw_pkg.sv
// Package: shared types and constants of the PCI master write engine.
// Assumes a 32-bit AD bus and the memory-write command code.
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_TURN,
        ST_ABORT
    } mw_state_e;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
    localparam logic [3:0] BE_NONE       = 4'hF;

endpackage

// File: rtl/mw_devsel_watch.sv
// Module: tracks whether the target has claimed the current transaction.
// Re-arms on every address phase. Raises expired in the last allowed data
// clock if DEVSEL# is still high. Assumes data_cyc is high only in data clocks.
module mw_devsel_watch #(
    parameter int TIMEOUT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic data_cyc,
    input  logic devsel_n,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic          seen_q;
    logic [CW-1:0] wait_q;

    // Count unclaimed data clocks since the last address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            wait_q <= '0;
        end else if (arm) begin
            seen_q <= 1'b0;
            wait_q <= '0;
        end else if (data_cyc && !seen_q) begin
            if (!devsel_n) begin
                seen_q <= 1'b1;
            end else begin
                wait_q <= wait_q + CW'(1);
            end
        end
    end

    // Timeout fires in the last clock that could still have carried a claim.
    always_comb begin
        expired = data_cyc && !seen_q && devsel_n && (wait_q == CW'(TIMEOUT - 1));
    end

endmodule

// File: rtl/mw_par_gen.sv
// Module: registered even-parity generator for the AD/C/BE# bus.
// Assumes the caller drives the bus value of the current clock. PAR follows one clock later.
module mw_par_gen #(
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ad_i,
    input  logic [BW-1:0] cbe_i,
    output logic          par
);
    logic par_q;

    // Register the parity of this clock's bus value for the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b0;
        end else begin
            par_q <= ^{ad_i, cbe_i};
        end
    end

    assign par = par_q;

endmodule

// File: rtl/mw_xfer_ctrl.sv
// Module: initiator sequencer for memory writes.
// Runs either one linear burst or one single-phase transaction per DWord.
// Assumes the bus is idle whenever GNT# is sampled low in the request or turnaround
// state, and that q_data/q_be_n follow q_idx in the same clock.
module mw_xfer_ctrl
    import mw_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = 32,
    parameter int BW    = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    start_addr,
    input  logic [CNT_W-1:0] dword_cnt,
    input  logic             burst_en,
    input  logic             gnt_n,
    input  logic             devsel_n,
    input  logic             trdy_n,
    input  logic             stop_n,
    input  logic             expired,
    input  logic [DW-1:0]    q_data,
    input  logic [BW-1:0]    q_be_n,
    output logic             req_n,
    output logic             frame_n,
    output logic             irdy_n,
    output logic [DW-1:0]    ad,
    output logic [BW-1:0]    cbe_n,
    output logic [CNT_W-1:0] q_idx,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             arm,
    output logic             data_cyc
);
    localparam int WA_W = DW - 2;

    mw_state_e        state_q, state_d;
    logic [CNT_W-1:0] idx_q, total_q;
    logic [WA_W-1:0]  base_q;
    logic             burst_q, req_q, err_q, done_q;

    logic             launch, last_word, xfer, stop_seen, frame_low;
    logic [WA_W-1:0]  txn_word;
    logic             unused_low_bits;

    assign unused_low_bits = ^start_addr[1:0];

    // Decode per-clock conditions from the registered state and sampled inputs.
    always_comb begin
        launch    = start && (dword_cnt != '0);
        last_word = (idx_q + CNT_W'(1)) == total_q;
        xfer      = (state_q == ST_DATA) && !trdy_n && !devsel_n;
        stop_seen = (state_q == ST_DATA) && !stop_n;
        frame_low = (state_q == ST_ADDR) ||
                    ((state_q == ST_DATA) && burst_q && !last_word);
        txn_word  = burst_q ? base_q : (base_q + WA_W'(idx_q));
    end

    // Pick the next sequencer state.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (launch) state_d = ST_REQ;
            ST_REQ:   if (!gnt_n) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_DATA;
            ST_DATA: begin
                if (expired) begin
                    state_d = frame_low ? ST_ABORT : ST_IDLE;
                end else if (stop_seen) begin
                    state_d = (frame_low && !(xfer && last_word)) ? ST_ABORT : ST_IDLE;
                end else if (xfer) begin
                    if (last_word)    state_d = ST_IDLE;
                    else if (burst_q) state_d = ST_DATA;
                    else              state_d = ST_TURN;
                end
            end
            ST_TURN:  state_d = gnt_n ? ST_REQ : ST_ADDR;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Hold sequence context, request, error and completion registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            total_q <= '0;
            base_q  <= '0;
            burst_q <= 1'b0;
            req_q   <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        total_q <= dword_cnt;
                        base_q  <= start_addr[DW-1:2];
                        burst_q <= burst_en;
                        idx_q   <= '0;
                        req_q   <= 1'b1;
                        err_q   <= 1'b0;
                    end
                end
                ST_REQ, ST_TURN: begin
                    if (!gnt_n && (burst_q || last_word)) req_q <= 1'b0;
                end
                ST_DATA: begin
                    if (xfer) idx_q <= idx_q + CNT_W'(1);
                    if (expired || (stop_seen && !(xfer && last_word))) err_q <= 1'b1;
                end
                default: ;
            endcase
            if ((state_d == ST_ABORT) || (state_d == ST_IDLE && state_q != ST_IDLE)) begin
                req_q <= 1'b0;
            end
        end
    end

    // Drive bus control, address/data and command/byte-enable lanes.
    always_comb begin
        req_n   = !req_q;
        frame_n = !frame_low;
        irdy_n  = !((state_q == ST_DATA) || (state_q == ST_ABORT));
        case (state_q)
            ST_ADDR: begin
                ad    = {txn_word, 2'b00};
                cbe_n = CMD_MEM_WRITE;
            end
            ST_DATA, ST_ABORT: begin
                ad    = q_data;
                cbe_n = q_be_n;
            end
            default: begin
                ad    = '0;
                cbe_n = BE_NONE;
            end
        endcase
    end

    assign q_idx    = idx_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign arm      = (state_q == ST_ADDR);
    assign data_cyc = (state_q == ST_DATA);

endmodule

// File: rtl/mw_pci_write_engine.sv
// Module: top of the PCI bus master write engine.
// Ties the sequencer, the DEVSEL# watchdog and the parity generator together.
// Assumes external logic turns the bus drivers on and off. This block drives plain levels.
module mw_pci_write_engine #(
    parameter int CNT_W          = 8,
    parameter int DEVSEL_TIMEOUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      start_addr,
    input  logic [CNT_W-1:0] dword_cnt,
    input  logic             burst_en,
    output logic [CNT_W-1:0] q_idx,
    input  logic [31:0]      q_data,
    input  logic [3:0]       q_be_n,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             req_n,
    input  logic             gnt_n,
    output logic             frame_n,
    output logic             irdy_n,
    input  logic             devsel_n,
    input  logic             trdy_n,
    input  logic             stop_n,
    output logic [31:0]      ad,
    output logic [3:0]       cbe_n,
    output logic             par
);
    localparam int DW = 32;
    localparam int BW = DW / 8;

    logic arm, data_cyc, expired;

    mw_xfer_ctrl #(.CNT_W(CNT_W), .DW(DW), .BW(BW)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .dword_cnt  (dword_cnt),
        .burst_en   (burst_en),
        .gnt_n      (gnt_n),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n),
        .expired    (expired),
        .q_data     (q_data),
        .q_be_n     (q_be_n),
        .req_n      (req_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .ad         (ad),
        .cbe_n      (cbe_n),
        .q_idx      (q_idx),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .arm        (arm),
        .data_cyc   (data_cyc)
    );

    mw_devsel_watch #(.TIMEOUT(DEVSEL_TIMEOUT)) i_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .data_cyc (data_cyc),
        .devsel_n (devsel_n),
        .expired  (expired)
    );

    mw_par_gen #(.DW(DW), .BW(BW)) i_par (
        .clk   (clk),
        .rst_n (rst_n),
        .ad_i  (ad),
        .cbe_i (cbe_n),
        .par   (par)
    );

endmodule

// File: rtl/mw_pci_write_chk.sv
// Module: protocol checker for the write engine, attached by bind.
// Observes only top-level ports.
module mw_pci_write_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_n,
    input logic        frame_n,
    input logic        irdy_n,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic [31:0] ad,
    input logic [3:0]  cbe_n,
    input logic        par,
    input logic        busy,
    input logic        done
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (req_n && frame_n && irdy_n && !busy));

    // R2
    addr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_n) && irdy_n) |-> (cbe_n == 4'b0111 && ad[1:0] == 2'b00));

    // R3
    irdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_n) && irdy_n) |=> !irdy_n);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && (trdy_n || devsel_n)) |=> (irdy_n || ($stable(ad) && $stable(cbe_n))));

    // R7
    no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && !irdy_n) |=> frame_n);

    // R9
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n || !irdy_n) |=> (par == ^{$past(ad), $past(cbe_n)}));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind mw_pci_write_engine mw_pci_write_chk i_chk (.*);

// File: tb/test_mw_pci_write_engine.sv
`timescale 1ns/1ps
// Bench: directed scenarios against a behavioural PCI target and arbiter.
module test_mw_pci_write_engine;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [31:0]      start_addr = '0;
    logic [CNT_W-1:0] dword_cnt = '0;
    logic             burst_en = 1'b0;
    logic [CNT_W-1:0] q_idx;
    logic [31:0]      q_data;
    logic [3:0]       q_be_n;
    logic             busy, done, err, req_n, frame_n, irdy_n, par;
    logic             gnt_n = 1'b1, devsel_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic [31:0]      ad;
    logic [3:0]       cbe_n;

    always #2.5 clk = ~clk;

    mw_pci_write_engine #(.CNT_W(CNT_W)) i_mw_pci_write_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .dword_cnt(dword_cnt), .burst_en(burst_en), .q_idx(q_idx), .q_data(q_data),
        .q_be_n(q_be_n), .busy(busy), .done(done), .err(err), .req_n(req_n),
        .gnt_n(gnt_n), .frame_n(frame_n), .irdy_n(irdy_n), .devsel_n(devsel_n),
        .trdy_n(trdy_n), .stop_n(stop_n), .ad(ad), .cbe_n(cbe_n), .par(par)
    );

    // Local word store.
    logic [31:0] src_data [0:15];
    logic [3:0]  src_be   [0:15];
    assign q_data = src_data[q_idx[3:0]];
    assign q_be_n = src_be[q_idx[3:0]];

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Target configuration and logs.
    int cfg_dev_dly = 1;
    int cfg_trdy_wait = 0;
    int cfg_stop_at = -1;

    logic [31:0] log_addr [0:15];
    logic [31:0] log_data [0:15];
    logic [3:0]  log_be   [0:15];
    logic        log_frame[0:15];
    int          n_log = 0;
    logic [31:0] a_ad  [0:15];
    logic [3:0]  a_cbe [0:15];
    logic        a_req [0:15];
    int          n_addr = 0;

    bit          active = 0, stopped = 0;
    int          since = 0, wait_cnt = 0, phase = 0;
    logic [31:0] cur_addr = '0, prev_ad = '0;
    logic [3:0]  prev_cbe = '0;
    bit          prev_bus = 0, prev_wait = 0, prev_addr = 0;

    // Target and arbiter model plus per-clock bus checks, evaluated mid-cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            gnt_n = 1'b1; devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
            active = 0; prev_bus = 0; prev_wait = 0; prev_addr = 0;
        end else begin
            bit addr_now, dv, tr, sp;
            gnt_n = req_n;
            if (prev_bus)
                chk(par == ^{prev_ad, prev_cbe}, "R9", "parity", 32'(par), 32'(^{prev_ad, prev_cbe}));
            if (prev_wait && !irdy_n) begin
                chk(ad == prev_ad, "R4", "AD held in wait", ad, prev_ad);
                chk(cbe_n == prev_cbe, "R4", "C/BE held in wait", 32'(cbe_n), 32'(prev_cbe));
            end
            if (prev_addr)
                chk(!irdy_n, "R3", "IRDY after address", 32'(irdy_n), 32'h0);
            addr_now = !frame_n && irdy_n;
            prev_wait = 0;
            if (addr_now) begin
                if (n_addr < 16) begin
                    a_ad[n_addr] = ad; a_cbe[n_addr] = cbe_n; a_req[n_addr] = req_n;
                end
                n_addr++;
                active = 1; stopped = 0; since = 0; phase = 0; wait_cnt = 0;
                cur_addr = ad;
                devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
            end else if (active && frame_n && irdy_n) begin
                active = 0;
                devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
            end else if (active) begin
                since++;
                dv = (since >= cfg_dev_dly);
                tr = dv && !stopped && (wait_cnt >= cfg_trdy_wait);
                sp = stopped || (tr && phase == cfg_stop_at);
                devsel_n = !dv; trdy_n = !tr; stop_n = !sp;
                if (!irdy_n && tr) begin
                    if (n_log < 16) begin
                        log_addr[n_log] = cur_addr + 32'(4 * phase);
                        log_data[n_log] = ad;
                        log_be[n_log] = cbe_n;
                        log_frame[n_log] = frame_n;
                    end
                    n_log++;
                    phase++;
                    wait_cnt = 0;
                    if (sp) stopped = 1;
                    if (frame_n) active = 0;
                end else begin
                    wait_cnt++;
                    prev_wait = !irdy_n;
                end
            end else begin
                devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
            end
            prev_ad = ad; prev_cbe = cbe_n;
            prev_bus = !frame_n || !irdy_n;
            prev_addr = addr_now;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic set_target(input int dev_dly, input int trdy_wait, input int stop_at);
        cfg_dev_dly = dev_dly; cfg_trdy_wait = trdy_wait; cfg_stop_at = stop_at;
    endtask

    // Launch one sequence and wait for its done pulse (R13).
    task automatic run_seq(input logic [31:0] a, input int n, input bit b);
        bit got = 0;
        bit busy_seen = 0;
        @(negedge clk);
        n_log = 0; n_addr = 0;
        start = 1'b1; start_addr = a; dword_cnt = CNT_W'(n); burst_en = b;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 400 && !got; k++) begin
            if (busy) busy_seen = 1;
            @(negedge clk);
            if (done) got = 1;
        end
        chk(got, "R13", "done pulse seen", 32'(got), 32'h1);
        chk(busy_seen, "R13", "busy during sequence", 32'(busy_seen), 32'h1);
        chk(!busy, "R13", "busy low with done", 32'(busy), 32'h0);
    endtask

    // Compare logged data phases against the store for words 0..n-1.
    task automatic check_words(input logic [31:0] base, input int n, input bit b, input string tag);
        chk(n_log == n, tag, "data phase count", 32'(n_log), 32'(n));
        for (int i = 0; i < n && i < n_log; i++) begin
            chk(log_addr[i] == ({base[31:2], 2'b00} + 32'(4 * i)), tag, "word address",
                log_addr[i], {base[31:2], 2'b00} + 32'(4 * i));
            chk(log_data[i] == src_data[i], "R4", "word data", log_data[i], src_data[i]);
            chk(log_be[i] == src_be[i], "R4", "word byte enables", 32'(log_be[i]), 32'(src_be[i]));
            if (b)
                chk(log_frame[i] == (i == n - 1), "R6", "FRAME level in burst phase",
                    32'(log_frame[i]), 32'(i == n - 1));
            else
                chk(log_frame[i] == 1'b1, "R7", "FRAME high in single phase", 32'(log_frame[i]), 32'h1);
        end
    endtask

    task automatic t_reset();
        chk(req_n && frame_n && irdy_n, "R1", "bus idle after reset", {29'h0, req_n, frame_n, irdy_n}, 32'h7);
        chk(!busy && !done && !err, "R1", "status low after reset", {29'h0, busy, done, err}, 32'h0);
    endtask

    task automatic t_burst_fast();
        set_target(1, 0, -1);
        run_seq(32'h1000_0040, 4, 1'b1);
        chk(n_addr == 1, "R5", "one address phase", 32'(n_addr), 32'h1);
        chk(a_cbe[0] == 4'b0111, "R2", "memory write command", 32'(a_cbe[0]), 32'h7);
        chk(a_ad[0] == 32'h1000_0040, "R2", "burst address", a_ad[0], 32'h1000_0040);
        chk(a_req[0] == 1'b1, "R8", "REQ released at burst address", 32'(a_req[0]), 32'h1);
        check_words(32'h1000_0040, 4, 1'b1, "R5");
        chk(!err, "R13", "no error", 32'(err), 32'h0);
    endtask

    task automatic t_burst_waits();
        set_target(2, 1, -1);
        run_seq(32'h2000_0107, 3, 1'b1);
        chk(a_ad[0] == 32'h2000_0104, "R2", "AD[1:0] cleared", a_ad[0], 32'h2000_0104);
        check_words(32'h2000_0104, 3, 1'b1, "R5");
        chk(!err, "R4", "no error with waits", 32'(err), 32'h0);
    endtask

    task automatic t_single_seq();
        set_target(1, 0, -1);
        run_seq(32'h3000_0000, 3, 1'b0);
        chk(n_addr == 3, "R7", "address phase per word", 32'(n_addr), 32'h3);
        for (int i = 0; i < 3 && i < n_addr; i++) begin
            chk(a_ad[i] == 32'h3000_0000 + 32'(4 * i), "R7", "single address", a_ad[i], 32'h3000_0000 + 32'(4 * i));
            chk(a_cbe[i] == 4'b0111, "R2", "command per transaction", 32'(a_cbe[i]), 32'h7);
            chk(a_req[i] == (i == 2), "R8", "REQ level at address", 32'(a_req[i]), 32'(i == 2));
        end
        check_words(32'h3000_0000, 3, 1'b0, "R7");
        chk(req_n, "R8", "REQ high after sequence", 32'(req_n), 32'h1);
    endtask

    task automatic t_burst_one();
        set_target(1, 0, -1);
        run_seq(32'h4000_0010, 1, 1'b1);
        chk(n_addr == 1, "R5", "single word burst address count", 32'(n_addr), 32'h1);
        check_words(32'h4000_0010, 1, 1'b1, "R6");
    endtask

    task automatic t_late_claim();
        set_target(4, 0, -1);
        run_seq(32'h5000_0000, 2, 1'b0);
        chk(!err, "R10", "claim on fourth clock accepted", 32'(err), 32'h0);
        check_words(32'h5000_0000, 2, 1'b0, "R10");
    endtask

    task automatic t_master_abort();
        set_target(100, 0, -1);
        run_seq(32'h6000_0000, 3, 1'b1);
        chk(err, "R10", "abort flags error (burst)", 32'(err), 32'h1);
        chk(n_log == 0, "R10", "no data phase completed", 32'(n_log), 32'h0);
        chk(frame_n && irdy_n && req_n, "R10", "bus released", {29'h0, frame_n, irdy_n, req_n}, 32'h7);
        run_seq(32'h6000_0100, 2, 1'b0);
        chk(err, "R10", "abort flags error (single)", 32'(err), 32'h1);
        chk(n_addr == 1, "R10", "no further address phase", 32'(n_addr), 32'h1);
    endtask

    task automatic t_target_stop();
        set_target(1, 0, 1);
        run_seq(32'h7000_0000, 4, 1'b1);
        chk(n_log == 2, "R11", "words before stop", 32'(n_log), 32'h2);
        chk(err, "R11", "stop flags error", 32'(err), 32'h1);
        chk(n_addr == 1, "R11", "no restart", 32'(n_addr), 32'h1);
        set_target(1, 0, 1);
        run_seq(32'h7000_1000, 2, 1'b1);
        chk(n_log == 2, "R11", "stop on last word transfers all", 32'(n_log), 32'h2);
        chk(!err, "R11", "stop on last word no error", 32'(err), 32'h0);
    endtask

    task automatic t_zero_count();
        bit ok = 1;
        @(negedge clk);
        start = 1'b1; start_addr = 32'h8000_0000; dword_cnt = '0; burst_en = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (!req_n || busy || !frame_n) ok = 0;
            @(negedge clk);
        end
        chk(ok, "R12", "zero count ignored", 32'(ok), 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            src_data[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(i << 4);
            src_be[i]   = 4'(i * 7 + 3);
        end
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst_fast();
        t_burst_waits();
        t_single_seq();
        t_burst_one();
        t_late_claim();
        t_master_abort();
        t_target_stop();
        t_zero_count();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule